// File: doc/BRIEF.md
# Temporal-Addressed Belt Operand Store

This block holds operands in a fixed-length queue that takes the place of a general register file. Results never name a destination. Every accepted result group enters at the front of the queue, and anything pushed past the last position is lost. Consumers name an operand by its age: position 0 is the newest value and position N is the (N+1)th newest. A value's position number rises by one for each later result that enters in front of it.

The store keeps one bank per call-nesting level and tags every entry with the frame that owns it. A call opens a fresh, empty view for the callee that holds only the copied argument values. A return brings back the caller's view as it was and pushes the callee's results onto it as one group.

Commands arrive on a valid/ready stream. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is a combinational function of the offered opcode and the current nesting level. A command that is offered but not taken has no effect, and the sender may change or withdraw it. The read ports are plain combinational lookups into the current view.

Top module: `belt_store`

## Requirements
- R1: After reset the current view is empty: every read port returns zero with its invalid flag set, and a drop command (opcode 0) is accepted.
- R2: A drop of one result (opcode 0, count 1) places `cmd_data` slot 0 at position 0, and every older value moves back by exactly one position.
- R3: A drop of count k (0 to DROP_W) pushes slots 0..k-1 as one group, with slot 0 at position 0 and slot j at position j, and moves older values back by k. Count 0 leaves the view unchanged.
- R4: The view holds at most BELT_LEN values. Values pushed beyond the last position are discarded, and the last position always holds the BELT_LEN-th newest value.
- R5: Each read port selects any position on its own, and several ports may read the same position in the same cycle and get the same value.
- R6: A read of a position that holds no valid value of the current frame returns zero and raises that port's invalid flag. A call or return argument taken from such a position is copied as zero.
- R7: A call (opcode 1) makes the callee's view current. That view contains exactly the count arguments read from the caller's positions in `cmd_pos`, with argument j at position j, and none of the caller's values are visible.
- R8: A return (opcode 2) reads count results from the callee's positions in `cmd_pos`, restores the caller's view exactly as it was before the call, and pushes the results onto it as a group, with result 0 at position 0.
- R9: `cmd_ready` is low for a call when the nesting level is already NEST-1, and low for a return at the outermost level. It is high otherwise. A command that is not taken changes nothing.
- R10: Values left in a callee's view on return are never visible to a later call at the same level. That call's view starts with only its own arguments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The offered command will be taken at the next edge |
| cmd_op | input | 2 | 0 drop, 1 call, 2 return, 3 no operation |
| cmd_cnt | input | $clog2(DROP_W+1) | Number of values in the group |
| cmd_data | input | DROP_W*DATA_W | Drop values, slot j at bits j*DATA_W upward |
| cmd_pos | input | DROP_W*$clog2(BELT_LEN) | Source positions for call arguments or return results |
| rd_pos | input | RD_PORTS*$clog2(BELT_LEN) | Position selected by each read port |
| rd_data | output | RD_PORTS*DATA_W | Value at each read port |
| rd_invalid | output | RD_PORTS | The selected position holds no value of the current frame |

## Verification
The assertions assume that `cmd_cnt` never exceeds DROP_W while `cmd_valid` is high, that DROP_W is smaller than BELT_LEN, and that NEST is at least 2. The bench draws group counts only from 0 to DROP_W and positions only inside the queue. It builds every call and return from the same bounded counts and reference model. It also keeps offering calls at full depth and returns at the outermost level, so the stall path is exercised without ever leaving these limits.

// File: rtl/belt_pkg.sv
package belt_pkg;

  typedef enum logic [1:0] {
    OP_DROP = 2'd0,
    OP_CALL = 2'd1,
    OP_RET  = 2'd2,
    OP_NOP  = 2'd3
  } belt_op_e;

endpackage

// File: rtl/belt_bank.sv
module belt_bank #(
  parameter int LEN    = 8,
  parameter int DROP_W = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  localparam int POS_W = $clog2(LEN),
  localparam int CNT_W = $clog2(DROP_W + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push_en,
  input  logic                           flush,
  input  logic [CNT_W-1:0]               push_cnt,
  input  logic [DROP_W-1:0][DATA_W-1:0]  push_data,
  input  logic [TAG_W-1:0]               push_tag,
  output logic [LEN-1:0][DATA_W-1:0]     ent_data,
  output logic [LEN-1:0][TAG_W-1:0]      ent_tag,
  output logic [LEN-1:0]                 ent_vld
);

  logic [LEN-1:0][DATA_W-1:0] grp_pad;
  logic [LEN-1:0][DATA_W-1:0] nxt_data;
  logic [LEN-1:0][TAG_W-1:0]  nxt_tag;
  logic [LEN-1:0]             nxt_vld;

  always_comb begin
    grp_pad = '0;
    for (int j = 0; j < DROP_W; j++) grp_pad[j] = push_data[j];
  end

  // Entry i takes group slot i when i < count, otherwise the entry count places older.
  always_comb begin
    for (int i = 0; i < LEN; i++) begin
      logic [POS_W-1:0] si;
      si = POS_W'(i) - POS_W'(push_cnt);
      if (i < int'(push_cnt)) begin
        nxt_data[i] = grp_pad[i];
        nxt_tag[i]  = push_tag;
        nxt_vld[i]  = 1'b1;
      end else if (flush) begin
        nxt_data[i] = '0;
        nxt_tag[i]  = '0;
        nxt_vld[i]  = 1'b0;
      end else begin
        nxt_data[i] = ent_data[si];
        nxt_tag[i]  = ent_tag[si];
        nxt_vld[i]  = ent_vld[si];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_data <= '0;
      ent_tag  <= '0;
      ent_vld  <= '0;
    end else if (push_en) begin
      ent_data <= nxt_data;
      ent_tag  <= nxt_tag;
      ent_vld  <= nxt_vld;
    end
  end

  AST_FRONT_IS_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    push_en && push_cnt != '0 |=> ent_vld[0] && ent_data[0] == $past(push_data[0])); // R3

  AST_SINGLE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    push_en && !flush && push_cnt == CNT_W'(1) |=> ent_data[1] == $past(ent_data[0])); // R2

  AST_FLUSH_TAIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    push_en && flush |=> !ent_vld[LEN-1]); // R10

endmodule

// File: rtl/belt_read_port.sv
module belt_read_port #(
  parameter int LEN    = 8,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  localparam int POS_W = $clog2(LEN)
) (
  input  logic [LEN-1:0][DATA_W-1:0] view_data,
  input  logic [LEN-1:0][TAG_W-1:0]  view_tag,
  input  logic [LEN-1:0]             view_vld,
  input  logic [TAG_W-1:0]           cur_tag,
  input  logic [POS_W-1:0]           pos,
  output logic [DATA_W-1:0]          data,
  output logic                       invalid
);

  logic hit;

  always_comb begin
    hit     = view_vld[pos] && (view_tag[pos] == cur_tag);
    data    = hit ? view_data[pos] : '0;
    invalid = !hit;
  end

endmodule

// File: rtl/belt_frame_ctl.sv
module belt_frame_ctl
  import belt_pkg::*;
#(
  parameter int NEST  = 4,
  parameter int TAG_W = 8,
  localparam int LVL_W = $clog2(NEST)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  belt_op_e         op,
  output logic [LVL_W-1:0] level,
  output logic [TAG_W-1:0] cur_tag,
  output logic [TAG_W-1:0] callee_tag,
  output logic [TAG_W-1:0] caller_tag,
  output logic             can_call,
  output logic             can_ret
);

  logic [NEST-1:0][TAG_W-1:0] fid;
  logic [TAG_W-1:0]           next_id;

  always_comb begin
    can_call   = level != LVL_W'(NEST - 1);
    can_ret    = level != '0;
    cur_tag    = fid[level];
    callee_tag = next_id;
    caller_tag = fid[level - 1'b1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= '0;
      fid     <= '0;
      next_id <= TAG_W'(1);
    end else if (fire) begin
      if (op == OP_CALL && can_call) begin
        fid[level + 1'b1] <= next_id;
        next_id           <= next_id + 1'b1;
        level             <= level + 1'b1;
      end else if (op == OP_RET && can_ret) begin
        level <= level - 1'b1;
      end
    end
  end

  AST_CALL_DEEPENS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == OP_CALL |=> level == $past(level) + 1'b1); // R7

  AST_RET_RESTORES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == OP_RET |=> cur_tag == $past(caller_tag)); // R8

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && (op == OP_CALL || op == OP_RET)) |=> $stable(level)); // R9

endmodule

// File: rtl/belt_store.sv
module belt_store
  import belt_pkg::*;
#(
  parameter int BELT_LEN = 8,
  parameter int DROP_W   = 4,
  parameter int RD_PORTS = 4,
  parameter int NEST     = 4,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 8,
  localparam int POS_W   = $clog2(BELT_LEN),
  localparam int CNT_W   = $clog2(DROP_W + 1),
  localparam int LVL_W   = $clog2(NEST)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [1:0]                   cmd_op,
  input  logic [CNT_W-1:0]             cmd_cnt,
  input  logic [DROP_W*DATA_W-1:0]     cmd_data,
  input  logic [DROP_W*POS_W-1:0]      cmd_pos,
  input  logic [RD_PORTS*POS_W-1:0]    rd_pos,
  output logic [RD_PORTS*DATA_W-1:0]   rd_data,
  output logic [RD_PORTS-1:0]          rd_invalid
);

  belt_op_e                  op;
  logic                      fire;
  logic [LVL_W-1:0]          level;
  logic [TAG_W-1:0]          cur_tag, callee_tag, caller_tag, push_tag;
  logic                      can_call, can_ret;

  logic [NEST-1:0][BELT_LEN-1:0][DATA_W-1:0] b_data;
  logic [NEST-1:0][BELT_LEN-1:0][TAG_W-1:0]  b_tag;
  logic [NEST-1:0][BELT_LEN-1:0]             b_vld;
  logic [BELT_LEN-1:0][DATA_W-1:0]           view_data;
  logic [BELT_LEN-1:0][TAG_W-1:0]            view_tag;
  logic [BELT_LEN-1:0]                       view_vld;

  logic [DROP_W-1:0][DATA_W-1:0] drop_vals, fetch_data, push_data;
  logic [DROP_W-1:0]             fetch_inv;
  logic [NEST-1:0]               push_en;
  logic                          flush;

  assign op        = belt_op_e'(cmd_op);
  assign drop_vals = cmd_data;

  always_comb begin
    case (op)
      OP_CALL: cmd_ready = can_call;
      OP_RET:  cmd_ready = can_ret;
      default: cmd_ready = 1'b1;
    endcase
    fire = cmd_valid && cmd_ready;
  end

  belt_frame_ctl #(.NEST(NEST), .TAG_W(TAG_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(op), .level(level),
    .cur_tag(cur_tag), .callee_tag(callee_tag), .caller_tag(caller_tag),
    .can_call(can_call), .can_ret(can_ret)
  );

  // Current view: the bank at the present nesting level.
  always_comb begin
    view_data = b_data[level];
    view_tag  = b_tag[level];
    view_vld  = b_vld[level];
  end

  // Argument and result fetch from the current view.
  for (genvar j = 0; j < DROP_W; j++) begin : g_fetch
    belt_read_port #(.LEN(BELT_LEN), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_fetch (
      .view_data(view_data), .view_tag(view_tag), .view_vld(view_vld),
      .cur_tag(cur_tag), .pos(cmd_pos[j*POS_W +: POS_W]),
      .data(fetch_data[j]), .invalid(fetch_inv[j])
    );

    AST_FETCH_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_inv[j] |-> fetch_data[j] == '0); // R6
  end

  // Target bank and tag per command kind.
  always_comb begin
    flush     = (op == OP_CALL);
    push_data = (op == OP_DROP) ? drop_vals : fetch_data;
    case (op)
      OP_CALL: push_tag = callee_tag;
      OP_RET:  push_tag = caller_tag;
      default: push_tag = cur_tag;
    endcase
    for (int k = 0; k < NEST; k++) begin
      push_en[k] = fire && (
          (op == OP_DROP && level == LVL_W'(k)) ||
          (op == OP_CALL && level + 1'b1 == LVL_W'(k)) ||
          (op == OP_RET  && level - 1'b1 == LVL_W'(k)));
    end
  end

  for (genvar k = 0; k < NEST; k++) begin : g_bank
    belt_bank #(.LEN(BELT_LEN), .DROP_W(DROP_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .push_en(push_en[k]), .flush(flush),
      .push_cnt(cmd_cnt), .push_data(push_data), .push_tag(push_tag),
      .ent_data(b_data[k]), .ent_tag(b_tag[k]), .ent_vld(b_vld[k])
    );
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    belt_read_port #(.LEN(BELT_LEN), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_rd (
      .view_data(view_data), .view_tag(view_tag), .view_vld(view_vld),
      .cur_tag(cur_tag), .pos(rd_pos[p*POS_W +: POS_W]),
      .data(rd_data[p*DATA_W +: DATA_W]), .invalid(rd_invalid[p])
    );

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_invalid[p] |-> rd_data[p*DATA_W +: DATA_W] == '0); // R6
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_cnt <= CNT_W'(DROP_W)); // R3

  AST_STALL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(b_data) && $stable(b_vld) && $stable(level)); // R9

endmodule

// File: tb/test_belt_store.sv
module test_belt_store;

  localparam int LEN  = 8;
  localparam int DW   = 4;
  localparam int RP   = 4;
  localparam int NEST = 4;
  localparam int PW   = $clog2(LEN);
  localparam int CW   = $clog2(DW + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid;
  logic              cmd_ready;
  logic [1:0]        cmd_op;
  logic [CW-1:0]     cmd_cnt;
  logic [DW*32-1:0]  cmd_data;
  logic [DW*PW-1:0]  cmd_pos;
  logic [RP*PW-1:0]  rd_pos;
  logic [RP*32-1:0]  rd_data;
  logic [RP-1:0]     rd_invalid;

  always #10 clk = ~clk;

  belt_store #(.BELT_LEN(LEN), .DROP_W(DW), .RD_PORTS(RP), .NEST(NEST), .DATA_W(32), .TAG_W(8))
  i_belt_store (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_cnt(cmd_cnt), .cmd_data(cmd_data), .cmd_pos(cmd_pos),
    .rd_pos(rd_pos), .rd_data(rd_data), .rd_invalid(rd_invalid)
  );

  int nvec = 0;
  int nbad = 0;

  logic [31:0] mdata [NEST][LEN];
  int          mcnt  [NEST];
  int          mlvl;
  logic [31:0] bv [DW];
  int          bp [DW];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [32:0] act, input logic [32:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input int p);
    return (p < mcnt[mlvl]) ? mdata[mlvl][p] : 32'h0;
  endfunction

  task automatic mpush(input int lvl, input int cnt, input logic [31:0] v [DW]);
    logic [31:0] tmp [LEN];
    for (int i = 0; i < LEN; i++)
      tmp[i] = (i < cnt) ? v[i] : mdata[lvl][i - cnt];
    for (int i = 0; i < LEN; i++) mdata[lvl][i] = tmp[i];
    mcnt[lvl] = (mcnt[lvl] + cnt > LEN) ? LEN : mcnt[lvl] + cnt;
  endtask

  task automatic view(input string req);
    for (int base = 0; base < LEN; base += RP) begin
      for (int q = 0; q < RP; q++) rd_pos[q*PW +: PW] = PW'(base + q);
      #1;
      for (int q = 0; q < RP; q++) begin
        logic [32:0] exp, act;
        exp = {1'(base + q >= mcnt[mlvl]), mread(base + q)};
        act = {rd_invalid[q], rd_data[q*32 +: 32]};
        chk(act == exp, req, $sformatf("position %0d {invalid,data}", base + q), act, exp);
      end
    end
  endtask

  task automatic same_pos(input int p, input string req);
    for (int q = 0; q < RP; q++) rd_pos[q*PW +: PW] = PW'(p);
    #1;
    for (int q = 0; q < RP; q++)
      chk(rd_data[q*32 +: 32] == mread(p), req, $sformatf("port %0d shared position %0d", q, p),
          33'(rd_data[q*32 +: 32]), 33'(mread(p)));
  endtask

  task automatic issue(input int op, input int cnt, input string req);
    logic [31:0] args [DW];
    bit          rdy_exp;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op[1:0];
    cmd_cnt   = cnt[CW-1:0];
    for (int j = 0; j < DW; j++) begin
      cmd_data[j*32 +: 32] = bv[j];
      cmd_pos[j*PW +: PW]  = PW'(bp[j]);
      args[j]              = mread(bp[j]);
    end
    #1;
    rdy_exp = (op == 1) ? (mlvl < NEST - 1) : (op == 2) ? (mlvl > 0) : 1'b1;
    chk(cmd_ready == rdy_exp, "R9", "cmd_ready", 33'(cmd_ready), 33'(rdy_exp));
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    if (rdy_exp) begin
      case (op)
        0: mpush(mlvl, cnt, bv);
        1: begin mcnt[mlvl + 1] = 0; mpush(mlvl + 1, cnt, args); mlvl++; end
        2: begin mlvl--; mpush(mlvl, cnt, args); end
        default: ;
      endcase
    end
    view(req);
  endtask

  task automatic set_vals(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] d);
    bv[0] = a; bv[1] = b; bv[2] = c; bv[3] = d;
  endtask

  task automatic set_pos(input int a, input int b, input int c, input int d);
    bp[0] = a; bp[1] = b; bp[2] = c; bp[3] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nvec++;
    nbad++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < NEST; l++) begin
      mcnt[l] = 0;
      for (int i = 0; i < LEN; i++) mdata[l][i] = '0;
    end
    mlvl      = 0;
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_op    = 2'd0;
    cmd_cnt   = '0;
    cmd_data  = '0;
    cmd_pos   = '0;
    rd_pos    = '0;
    set_vals(0, 0, 0, 0);
    set_pos(0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    view("R1");
    chk(cmd_ready == 1'b1, "R1", "ready for drop after reset", 33'(cmd_ready), 33'd1);

    // Single drops and grouped drops
    set_vals(32'h11, 0, 0, 0);                   issue(0, 1, "R2");
    set_vals(32'h22, 0, 0, 0);                   issue(0, 1, "R2");
    set_vals(32'hA0, 32'hB0, 32'hC0, 0);         issue(0, 3, "R3");
    set_vals(32'hDEAD, 32'hDEAD, 32'hDEAD, 32'hDEAD); issue(0, 0, "R3");
    // Push past the end of the queue
    set_vals(32'h101, 32'h102, 32'h103, 32'h104); issue(0, 4, "R4");
    set_vals(32'h201, 32'h202, 32'h203, 32'h204); issue(0, 4, "R4");
    same_pos(2, "R5");
    same_pos(LEN - 1, "R5");

    // Call with arguments, then a nested call reading an empty position
    set_pos(0, 3, LEN - 1, 1);                   issue(1, 3, "R7");
    set_pos(5, 0, 1, 2);                         issue(1, 2, "R6");
    set_vals(32'h301, 0, 0, 0);                  issue(0, 1, "R3");
    set_pos(0, 1, 2, 0);                         issue(1, 3, "R7");
    // Nesting full: call must stall
    issue(1, 1, "R9");
    // Unwind with results
    set_pos(1, 0, 2, 3);                         issue(2, 2, "R8");
    issue(2, 1, "R8");
    issue(2, 4, "R8");
    // Outermost level: return must stall
    issue(2, 1, "R9");
    // A fresh call at a reused level sees only its arguments
    issue(1, 0, "R10");
    set_pos(0, 0, 0, 0);                         issue(2, 0, "R8");

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int r, op, cnt;
      string req;
      r   = int'($urandom_range(0, 9));
      op  = (r < 6) ? 0 : (r < 8) ? 1 : 2;
      cnt = int'($urandom_range(0, DW));
      for (int j = 0; j < DW; j++) begin
        bv[j] = $urandom;
        bp[j] = int'($urandom_range(0, LEN - 1));
      end
      req = (op == 0) ? "R3" : (op == 1) ? "R7" : "R8";
      issue(op, cnt, req);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule